// File: doc/BRIEF.md
# Transmit Frame Handoff Controller

This block arbitrates ownership of a single transmit frame buffer between firmware and a host-side read path. Firmware fills the buffer, programs a frame length and raises a "frame ready" request. A prefetch engine separately reports, with a one-cycle pulse, that the first data has been staged. The host read path issues one read request per byte.

When a read request arrives while the buffer is not held, the controller decides whether a frame may go out. The frame must be marked ready, prefetch must be complete and the length must be non-zero. If all three hold, the controller takes the buffer lock, reads byte 0 from the buffer memory and then serves each later request with the next byte, without checking again. The buffer memory is synchronous, so each byte is presented to the host one cycle after its request. After the last byte has been read, the controller raises a single-cycle end-of-transfer pulse and drops the ready flag, the prefetch flag and the lock together. A request that fails the check sets a sticky "no frame" interrupt status instead and reads nothing.

Top module: `tx_frame_handoff`

## Requirements
- R1: After reset, the ready flag, the prefetch flag, the lock, the interrupt status, the read-valid output and the end-of-transfer output are all 0.
- R2: While the buffer is not held, a pulse on `fw_set_ready` sets the ready flag and a pulse on `fw_clr_ready` clears it. When both pulse in the same cycle, set wins.
- R3: A read request while unlocked, with ready=1, prefetch=1 and length≠0, is granted. It reads buffer address 0, and the lock reads 1 from the next cycle on, unless the frame length is 1.
- R4: A read request while unlocked that fails the check sets `irq_no_frame` on the next cycle and issues no buffer read. The status stays 1 until a `fw_irq_clr` pulse. A new failure in the same cycle as the clear keeps it at 1.
- R5: Each read request served while locked reads the next buffer address in order. Every served request yields `host_rd_valid` for exactly one cycle, one cycle later, carrying the buffer byte at that address.
- R6: One cycle after the request for byte length-1 is served, `eot` is high for exactly one cycle. In that same cycle the ready flag, the prefetch flag and the lock read 0. This completion clear wins over a `fw_set_ready` or `prefetch_done` pulse that arrives in the same cycle as the last request.
- R7: While the lock is held, including the cycle of the grant, `fw_set_ready`, `fw_clr_ready` and `fw_len_we` have no effect. The frame in flight keeps its original length, and the ready flag keeps its value.
- R8: A frame length of 0 counts as "no frame": a request with that length is rejected as in R4.
- R9: A `prefetch_done` pulse sets the prefetch flag. Only completion of a frame clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fw_set_ready | input | 1 | Firmware pulse: mark frame ready |
| fw_clr_ready | input | 1 | Firmware pulse: withdraw frame ready |
| fw_len_we | input | 1 | Firmware pulse: load frame length |
| fw_len_wdata | input | LEN_W | Frame length in bytes |
| fw_irq_clr | input | 1 | Firmware pulse: clear no-frame status |
| prefetch_done | input | 1 | Prefetch engine pulse: first data staged |
| host_rd_req | input | 1 | Host read request, one byte per pulse |
| buf_rd_en | output | 1 | Buffer memory read enable |
| buf_rd_addr | output | LEN_W | Buffer memory byte address |
| buf_rd_data | input | DATA_W | Buffer memory read data, one cycle after enable |
| host_rd_valid | output | 1 | Byte valid toward the host |
| host_rd_data | output | DATA_W | Byte toward the host |
| eot | output | 1 | End-of-transfer pulse |
| frame_ready | output | 1 | Ready flag |
| prefetch_ok | output | 1 | Prefetch flag |
| buf_locked | output | 1 | Buffer lock |
| irq_no_frame | output | 1 | Sticky no-frame interrupt status |

## Verification
Two pairs of events can land in the same cycle. The first pair is completion and a fresh firmware ready or prefetch pulse. The bench drives `fw_set_ready` together with the only request of a one-byte frame, and `prefetch_done` together with the last request of a longer frame. It then judges that both flags read 0 one cycle later. The second pair is a rejected request and an interrupt clear: the bench drives both in one cycle and expects the status to stay 1. A scoreboard pairs every granted byte with its expected value and its end-of-transfer marking, so a byte that comes out late, is missing or appears unrequested is caught.

// File: rtl/txh_pkg.sv
package txh_pkg;

  // Decision taken for one host read request
  typedef enum logic [1:0] {
    REQ_IDLE   = 2'd0,
    REQ_GRANT  = 2'd1,
    REQ_STREAM = 2'd2,
    REQ_REJECT = 2'd3
  } req_kind_e;

endpackage

// File: rtl/txh_gate.sv
module txh_gate
  import txh_pkg::*;
#(
  parameter int LEN_W = 8
) (
  input  logic             rd_req,
  input  logic             lock,
  input  logic             ready,
  input  logic             pf_ok,
  input  logic [LEN_W-1:0] len,
  input  logic [LEN_W-1:0] cnt,
  output req_kind_e        kind,
  output logic             grant,
  output logic             reject,
  output logic             serve,
  output logic             last,
  output logic [LEN_W-1:0] rd_addr
);

  localparam logic [LEN_W-1:0] ONE = LEN_W'(1);

  logic len_nz;
  logic can_start;

  assign len_nz    = (len != '0);
  assign can_start = ready & pf_ok & len_nz;

  always_comb begin
    kind = REQ_IDLE;
    if (rd_req) begin
      if (lock)           kind = REQ_STREAM;
      else if (can_start) kind = REQ_GRANT;
      else                kind = REQ_REJECT;
    end
  end

  assign grant   = (kind == REQ_GRANT);
  assign reject  = (kind == REQ_REJECT);
  assign serve   = (kind == REQ_GRANT) | (kind == REQ_STREAM);
  assign rd_addr = lock ? cnt : '0;

  always_comb begin
    last = 1'b0;
    if (kind == REQ_GRANT)  last = (len == ONE);
    if (kind == REQ_STREAM) last = (cnt == (len - ONE));
  end

endmodule

// File: rtl/txh_flags.sv
module txh_flags #(
  parameter int LEN_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fw_set_ready,
  input  logic             fw_clr_ready,
  input  logic             fw_len_we,
  input  logic [LEN_W-1:0] fw_len_wdata,
  input  logic             fw_irq_clr,
  input  logic             prefetch_done,
  input  logic             grant,
  input  logic             reject,
  input  logic             finish,
  output logic             ready,
  output logic             pf_ok,
  output logic             lock,
  output logic [LEN_W-1:0] len,
  output logic             irq
);

  logic             ready_q, ready_d, ready_en;
  logic             pf_q, pf_d, pf_en;
  logic             lock_q, lock_d, lock_en;
  logic [LEN_W-1:0] len_q, len_d;
  logic             len_en;
  logic             irq_q, irq_d, irq_en;
  logic             held;

  assign held = lock_q | grant;

  always_comb begin
    ready_d  = ready_q;
    ready_en = 1'b0;
    if (finish) begin
      ready_d  = 1'b0;
      ready_en = 1'b1;
    end else if (!held && fw_set_ready) begin
      ready_d  = 1'b1;
      ready_en = 1'b1;
    end else if (!held && fw_clr_ready) begin
      ready_d  = 1'b0;
      ready_en = 1'b1;
    end
  end

  always_comb begin
    pf_d  = pf_q;
    pf_en = 1'b0;
    if (finish) begin
      pf_d  = 1'b0;
      pf_en = 1'b1;
    end else if (prefetch_done) begin
      pf_d  = 1'b1;
      pf_en = 1'b1;
    end
  end

  always_comb begin
    lock_d  = lock_q;
    lock_en = 1'b0;
    if (finish) begin
      lock_d  = 1'b0;
      lock_en = 1'b1;
    end else if (grant) begin
      lock_d  = 1'b1;
      lock_en = 1'b1;
    end
  end

  always_comb begin
    len_d  = fw_len_wdata;
    len_en = fw_len_we & ~held;
  end

  always_comb begin
    irq_d  = irq_q;
    irq_en = 1'b0;
    if (reject) begin
      irq_d  = 1'b1;
      irq_en = 1'b1;
    end else if (fw_irq_clr) begin
      irq_d  = 1'b0;
      irq_en = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ready_q <= 1'b0;
      pf_q    <= 1'b0;
      lock_q  <= 1'b0;
      len_q   <= '0;
      irq_q   <= 1'b0;
    end else begin
      if (ready_en) ready_q <= ready_d;
      if (pf_en)    pf_q    <= pf_d;
      if (lock_en)  lock_q  <= lock_d;
      if (len_en)   len_q   <= len_d;
      if (irq_en)   irq_q   <= irq_d;
    end
  end

  assign ready = ready_q;
  assign pf_ok = pf_q;
  assign lock  = lock_q;
  assign len   = len_q;
  assign irq   = irq_q;

  AST_LOCK_NEEDS_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
    lock_q |-> (ready_q && pf_q)); // R3
  AST_IRQ_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_q && !fw_irq_clr) |=> irq_q); // R4
  AST_LEN_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    lock_q |=> $stable(len_q)); // R7
  AST_PF_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (prefetch_done && !finish) |=> pf_q); // R9

endmodule

// File: rtl/txh_stream.sv
module txh_stream #(
  parameter int LEN_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             serve,
  input  logic             last,
  output logic [LEN_W-1:0] cnt,
  output logic             rd_valid,
  output logic             eot
);

  logic [LEN_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;
  logic             valid_q;
  logic             eot_q;

  always_comb begin
    cnt_en = serve;
    cnt_d  = last ? '0 : (cnt_q + LEN_W'(1));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      valid_q <= 1'b0;
      eot_q   <= 1'b0;
    end else begin
      if (cnt_en) cnt_q <= cnt_d;
      valid_q <= serve;
      eot_q   <= serve & last;
    end
  end

  assign cnt      = cnt_q;
  assign rd_valid = valid_q;
  assign eot      = eot_q;

  AST_VALID_AFTER_SERVE: assert property (@(posedge clk) disable iff (!rst_n)
    serve |=> valid_q); // R5
  AST_EOT_WITH_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    eot_q |-> valid_q); // R6

endmodule

// File: rtl/tx_frame_handoff.sv
module tx_frame_handoff
  import txh_pkg::*;
#(
  parameter int LEN_W  = 8,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fw_set_ready,
  input  logic              fw_clr_ready,
  input  logic              fw_len_we,
  input  logic [LEN_W-1:0]  fw_len_wdata,
  input  logic              fw_irq_clr,
  input  logic              prefetch_done,
  input  logic              host_rd_req,
  output logic              buf_rd_en,
  output logic [LEN_W-1:0]  buf_rd_addr,
  input  logic [DATA_W-1:0] buf_rd_data,
  output logic              host_rd_valid,
  output logic [DATA_W-1:0] host_rd_data,
  output logic              eot,
  output logic              frame_ready,
  output logic              prefetch_ok,
  output logic              buf_locked,
  output logic              irq_no_frame
);

  req_kind_e        kind;
  logic             grant, reject, serve, last;
  logic [LEN_W-1:0] rd_addr;
  logic [LEN_W-1:0] cnt;
  logic [LEN_W-1:0] len;
  logic             ready, pf_ok, lock, irq;
  logic             finish;

  assign finish = serve & last;

  txh_gate #(.LEN_W(LEN_W)) u_gate (
    .rd_req  (host_rd_req),
    .lock    (lock),
    .ready   (ready),
    .pf_ok   (pf_ok),
    .len     (len),
    .cnt     (cnt),
    .kind    (kind),
    .grant   (grant),
    .reject  (reject),
    .serve   (serve),
    .last    (last),
    .rd_addr (rd_addr)
  );

  txh_flags #(.LEN_W(LEN_W)) u_flags (
    .clk           (clk),
    .rst_n         (rst_n),
    .fw_set_ready  (fw_set_ready),
    .fw_clr_ready  (fw_clr_ready),
    .fw_len_we     (fw_len_we),
    .fw_len_wdata  (fw_len_wdata),
    .fw_irq_clr    (fw_irq_clr),
    .prefetch_done (prefetch_done),
    .grant         (grant),
    .reject        (reject),
    .finish        (finish),
    .ready         (ready),
    .pf_ok         (pf_ok),
    .lock          (lock),
    .len           (len),
    .irq           (irq)
  );

  txh_stream #(.LEN_W(LEN_W)) u_stream (
    .clk      (clk),
    .rst_n    (rst_n),
    .serve    (serve),
    .last     (last),
    .cnt      (cnt),
    .rd_valid (host_rd_valid),
    .eot      (eot)
  );

  assign buf_rd_en    = serve;
  assign buf_rd_addr  = rd_addr;
  assign host_rd_data = buf_rd_data;
  assign frame_ready  = ready;
  assign prefetch_ok  = pf_ok;
  assign buf_locked   = lock;
  assign irq_no_frame = irq;

  AST_EOT_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
    eot |-> (!ready && !pf_ok && !lock)); // R6
  AST_EOT_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    eot |=> !eot); // R6
  AST_CNT_IN_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
    lock |-> (cnt < len)); // R5
  AST_REJECT_NO_READ: assert property (@(posedge clk) disable iff (!rst_n)
    reject |-> !buf_rd_en); // R4
  AST_ZERO_LEN_REJECT: assert property (@(posedge clk) disable iff (!rst_n)
    (host_rd_req && !lock && len == '0) |=> (irq && !host_rd_valid)); // R8

endmodule

// File: tb/tb_tx_frame_handoff.sv
module tb_tx_frame_handoff;

  localparam int LEN_W  = 8;
  localparam int DATA_W = 8;

  logic              clk = 1'b0;
  logic              rst_n;
  logic              fw_set_ready, fw_clr_ready, fw_len_we, fw_irq_clr;
  logic [LEN_W-1:0]  fw_len_wdata;
  logic              prefetch_done, host_rd_req;
  logic              buf_rd_en;
  logic [LEN_W-1:0]  buf_rd_addr;
  logic [DATA_W-1:0] buf_rd_data;
  logic              host_rd_valid;
  logic [DATA_W-1:0] host_rd_data;
  logic              eot, frame_ready, prefetch_ok, buf_locked, irq_no_frame;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  typedef struct packed {
    logic [DATA_W-1:0] data;
    logic              last;
  } exp_t;
  exp_t sb[$];

  logic [DATA_W-1:0] mem [0:(1<<LEN_W)-1];

  always #10 clk = ~clk; // 50 MHz

  tx_frame_handoff #(.LEN_W(LEN_W), .DATA_W(DATA_W)) dut (
    .clk(clk), .rst_n(rst_n),
    .fw_set_ready(fw_set_ready), .fw_clr_ready(fw_clr_ready),
    .fw_len_we(fw_len_we), .fw_len_wdata(fw_len_wdata),
    .fw_irq_clr(fw_irq_clr), .prefetch_done(prefetch_done),
    .host_rd_req(host_rd_req),
    .buf_rd_en(buf_rd_en), .buf_rd_addr(buf_rd_addr), .buf_rd_data(buf_rd_data),
    .host_rd_valid(host_rd_valid), .host_rd_data(host_rd_data),
    .eot(eot), .frame_ready(frame_ready), .prefetch_ok(prefetch_ok),
    .buf_locked(buf_locked), .irq_no_frame(irq_no_frame)
  );

  // synchronous buffer memory model
  always @(posedge clk) if (buf_rd_en) buf_rd_data <= mem[buf_rd_addr];

  function automatic logic [DATA_W-1:0] pat(int i);
    return DATA_W'((i * 37 + 11) ^ 8'h5A);
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // monitor: pops the scoreboard as bytes come out
  always @(negedge clk) begin
    if (rst_n) begin
      if (host_rd_valid) begin
        if (sb.size() == 0) begin
          chk(0, "R5", "unexpected byte", host_rd_data, -1);
        end else begin
          exp_t e;
          e = sb.pop_front();
          chk(host_rd_data == e.data, "R5", "byte value", host_rd_data, e.data);
          chk(eot == e.last, "R6", "eot with byte", eot, e.last);
        end
      end else if (eot) begin
        chk(0, "R6", "eot without byte", 1, 0);
      end
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic idle_inputs();
    fw_set_ready = 0; fw_clr_ready = 0; fw_len_we = 0; fw_irq_clr = 0;
    prefetch_done = 0; host_rd_req = 0; fw_len_wdata = '0;
  endtask

  task automatic step();
    @(negedge clk);
    idle_inputs();
  endtask

  task automatic set_len(input int n);
    fw_len_we = 1; fw_len_wdata = LEN_W'(n); step();
  endtask

  task automatic arm();
    fw_set_ready = 1; prefetch_done = 1; step();
  endtask

  // driver: issues n requests of a granted frame, pushes expected bytes
  task automatic send(input int n, input int gap);
    for (int i = 0; i < n; i++) begin
      sb.push_back('{data: pat(i), last: (i == n - 1)});
      host_rd_req = 1;
      step();
      for (int g = 0; g < gap; g++) step();
    end
  endtask

  task automatic settle();
    step(); step();
  endtask

  initial begin
    for (int i = 0; i < (1 << LEN_W); i++) mem[i] = pat(i);
    idle_inputs();
    rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    step();

    // R1 reset state
    chk(!frame_ready && !prefetch_ok && !buf_locked, "R1", "flags after reset",
        {frame_ready, prefetch_ok, buf_locked}, 0);
    chk(!irq_no_frame && !host_rd_valid && !eot, "R1", "outputs after reset",
        {irq_no_frame, host_rd_valid, eot}, 0);

    // R4 request with nothing ready is rejected
    host_rd_req = 1; step();
    chk(irq_no_frame, "R4", "irq after reject", irq_no_frame, 1);
    step();
    chk(irq_no_frame, "R4", "irq sticky", irq_no_frame, 1);
    fw_irq_clr = 1; step();
    chk(!irq_no_frame, "R4", "irq cleared", irq_no_frame, 0);
    host_rd_req = 1; step();
    fw_irq_clr = 1; host_rd_req = 1; step();
    chk(irq_no_frame, "R4", "reject beats clear", irq_no_frame, 1);
    fw_irq_clr = 1; step();

    // R2 set / clear / both
    fw_set_ready = 1; step();
    chk(frame_ready, "R2", "set ready", frame_ready, 1);
    fw_clr_ready = 1; step();
    chk(!frame_ready, "R2", "clear ready", frame_ready, 0);
    fw_set_ready = 1; fw_clr_ready = 1; step();
    chk(frame_ready, "R2", "set wins", frame_ready, 1);

    // ready without prefetch -> reject, ready kept
    set_len(4);
    host_rd_req = 1; step();
    chk(irq_no_frame && frame_ready && !buf_locked, "R4", "reject without prefetch",
        {irq_no_frame, frame_ready, buf_locked}, 6);
    fw_irq_clr = 1; step();

    // R9 prefetch sets flag
    prefetch_done = 1; step();
    chk(prefetch_ok, "R9", "prefetch flag set", prefetch_ok, 1);

    // R3 R5 R6 back-to-back 4-byte frame
    sb.push_back('{data: pat(0), last: 1'b0});
    host_rd_req = 1; step();
    chk(buf_locked, "R3", "lock after grant", buf_locked, 1);
    send_rest(4, 0);
    step();
    chk(!frame_ready && !prefetch_ok && !buf_locked, "R6", "flags released",
        {frame_ready, prefetch_ok, buf_locked}, 0);
    chk(!irq_no_frame, "R3", "no irq on grant", irq_no_frame, 0);

    // R7 firmware writes ignored while locked, gaps between requests
    arm(); set_len(5);
    sb.push_back('{data: pat(0), last: 1'b0});
    host_rd_req = 1; fw_clr_ready = 1; fw_len_we = 1; fw_len_wdata = 8'd2; step();
    chk(frame_ready && buf_locked, "R7", "clear ignored in grant cycle",
        {frame_ready, buf_locked}, 3);
    fw_clr_ready = 1; fw_len_we = 1; fw_len_wdata = 8'd3; step();
    chk(frame_ready, "R7", "clear ignored while locked", frame_ready, 1);
    send_rest(5, 2);
    settle();
    chk(!buf_locked && sb.size() == 0, "R7", "original length kept",
        sb.size(), 0);

    // R6 collision: one-byte frame with set_ready in the same cycle
    arm(); set_len(1);
    sb.push_back('{data: pat(0), last: 1'b1});
    host_rd_req = 1; fw_set_ready = 1; step();
    chk(!frame_ready && !buf_locked, "R6", "completion beats set",
        {frame_ready, buf_locked}, 0);

    // R6 collision: prefetch pulse with last request of a 3-byte frame
    arm(); set_len(3);
    sb.push_back('{data: pat(0), last: 1'b0}); host_rd_req = 1; step();
    sb.push_back('{data: pat(1), last: 1'b0}); host_rd_req = 1; step();
    sb.push_back('{data: pat(2), last: 1'b1}); host_rd_req = 1; prefetch_done = 1; step();
    chk(!prefetch_ok, "R6", "completion beats prefetch", prefetch_ok, 0);

    // after completion a request is rejected
    settle();
    host_rd_req = 1; step();
    chk(irq_no_frame, "R6", "request after completion rejected", irq_no_frame, 1);
    fw_irq_clr = 1; step();

    // R8 zero length
    arm(); set_len(0);
    host_rd_req = 1; step();
    chk(irq_no_frame && !buf_locked, "R8", "zero length rejected",
        {irq_no_frame, buf_locked}, 2);
    fw_irq_clr = 1; step();

    settle();
    chk(sb.size() == 0, "R5", "scoreboard drained", sb.size(), 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  // remaining requests of a frame whose byte 0 was already requested
  task automatic send_rest(input int n, input int gap);
    for (int g = 0; g < gap; g++) step();
    for (int i = 1; i < n; i++) begin
      sb.push_back('{data: pat(i), last: (i == n - 1)});
      host_rd_req = 1;
      step();
      for (int g = 0; g < gap; g++) step();
    end
  endtask

endmodule